// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a two-level translation table held in memory. A client presents one request at a time, carrying the virtual address, a write flag and a user flag. The walker reads a first-level descriptor. That descriptor either maps a whole 1 MB section or points to a second-level table of 4 KB small pages. When it points to a table, the walker reads a second-level descriptor as well. It then checks the domain named by the first-level descriptor and the access permission that applies to the request.

Descriptors come in through a plain read port that has one read outstanding at most. The walker raises a request strobe with a word address, and the memory answers later with a data-valid strobe. When the walk finishes, the block gives a one-cycle completion pulse. With it comes either the physical address and the cacheable and bufferable attributes, or a fault code and the virtual address that faulted. The table base and the 16-entry domain control word are configuration inputs.

Top module: `xlat_walker`

## Requirements
- R1: After synchronous reset, req_ready is 1, done is 0 and mem_req is 0.
- R2: The first memory read of every walk uses the address {cfg_ttb[31:14], req_vaddr[31:20], 2'b00}. Bits 13:0 of cfg_ttb are ignored.
- R3: First-level descriptor bits 1:0 select the kind: 01 is a pointer to a second-level table and 10 is a section. 00 and 11 end the walk with fault code 1 after one memory read.
- R4: A section that passes its checks gives the physical address {desc1[31:20], vaddr[19:0]}, with bufferable = desc1[2] and cacheable = desc1[3]. The walk makes no second memory read.
- R5: For a table pointer, the second memory read uses the address {desc1[31:10], vaddr[19:12], 2'b00}.
- R6: Second-level descriptor bits 1:0 equal to 10 mark a small page. Any other value (00 invalid, 01 large, 11) gives fault code 2. A small page that passes its checks gives {desc2[31:12], vaddr[11:0]}, with bufferable = desc2[2] and cacheable = desc2[3].
- R7: The domain number is desc1[8:5], and its 2-bit mode is cfg_dac[2n+1:2n]. Mode 00 and mode 10 give fault code 3. For a table pointer this fault comes before any second-level read. Mode 11 skips the permission check. Mode 01 applies the permission check.
- R8: The permission field is desc1[11:10] for a section. For a small page it is desc2[5:4], [7:6], [9:8] or [11:10], picked by vaddr[11:10] equal to 0, 1, 2 or 3. Code 0 denies all access. Code 1 allows supervisor only. Code 2 also allows user reads. Code 3 allows everything. A denied access gives fault code 4.
- R9: done is high for exactly one cycle per walk. done_fault is 1 exactly when done_code is not 0. On a fault, done_pa, done_cacheable and done_bufferable are 0 and done_fault_va equals the request address. On success, done_fault_va is 0.
- R10: req_ready is low from the cycle after a request is accepted until the walk completes. mem_req is a single-cycle strobe, and a new read is issued only after the previous one has been answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access |
| req_user | input | 1 | 1 for user privilege, 0 for supervisor |
| cfg_ttb | input | 32 | First-level table base, 16 KB aligned |
| cfg_dac | input | 32 | Sixteen 2-bit domain modes |
| mem_req | output | 1 | Descriptor read strobe |
| mem_addr | output | 32 | Descriptor word address |
| mem_rvalid | input | 1 | Descriptor read data valid |
| mem_rdata | input | 32 | Descriptor read data |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk ended in a fault |
| done_code | output | 3 | 0 none, 1 level-1, 2 level-2, 3 domain, 4 permission |
| done_pa | output | 32 | Translated physical address |
| done_cacheable | output | 1 | Cacheable attribute of the mapping |
| done_bufferable | output | 1 | Bufferable attribute of the mapping |
| done_fault_va | output | 32 | Virtual address of a faulting walk |

## Verification
The assertions take for granted that mem_rvalid rises only while the walker waits for a descriptor, one answer per strobe. They also assume that cfg_ttb and cfg_dac hold still during a walk. The bench memory model answers each strobe exactly once, after a delay of zero to two extra cycles, and it changes the configuration only between walks. Within those limits the bench sweeps every first- and second-level type, every domain mode at several domain positions, every permission code on every subpage, and all four user and write combinations.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_L1_XLAT = 3'd1,
    FLT_L2_XLAT = 3'd2,
    FLT_DOMAIN  = 3'd3,
    FLT_PERM    = 3'd4
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_FETCH,
    ST_L1_DECODE,
    ST_L2_FETCH,
    ST_L2_DECODE,
    ST_DONE
  } walk_st_e;

  localparam logic [1:0] L1K_TABLE   = 2'b01;
  localparam logic [1:0] L1K_SECTION = 2'b10;
  localparam logic [1:0] L2K_SMALL   = 2'b10;

  localparam logic [1:0] AP_NONE     = 2'd0;
  localparam logic [1:0] AP_SUPER    = 2'd1;
  localparam logic [1:0] AP_USER_RD  = 2'd2;
  localparam logic [1:0] AP_ALL      = 2'd3;

endpackage

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int L1_IDX_W   = 12,
  parameter int L2_IDX_W   = 8,
  parameter int PAGE_OFF_W = 12
) (
  input  logic [ADDR_W-1:0] ttb,
  input  logic [ADDR_W-1:0] va,
  input  logic [ADDR_W-1:0] l1_desc,
  input  logic [ADDR_W-1:0] l2_desc,
  output logic [ADDR_W-1:0] l1_addr,
  output logic [ADDR_W-1:0] l2_addr,
  output logic [ADDR_W-1:0] sect_pa,
  output logic [ADDR_W-1:0] page_pa
);
  localparam int SECT_OFF_W = L2_IDX_W + PAGE_OFF_W;
  localparam int TTB_LO     = L1_IDX_W + 2;
  localparam int L2_BASE_LO = L2_IDX_W + 2;

  // table walk address formation: base bits, index bits, word alignment
  assign l1_addr = {ttb[ADDR_W-1:TTB_LO], va[ADDR_W-1:SECT_OFF_W], 2'b00};
  assign l2_addr = {l1_desc[ADDR_W-1:L2_BASE_LO],
                    va[SECT_OFF_W-1:PAGE_OFF_W], 2'b00};
  assign sect_pa = {l1_desc[ADDR_W-1:SECT_OFF_W], va[SECT_OFF_W-1:0]};
  assign page_pa = {l2_desc[ADDR_W-1:PAGE_OFF_W], va[PAGE_OFF_W-1:0]};

  logic unused_bits;
  assign unused_bits = ^{ttb[TTB_LO-1:0], l1_desc[L2_BASE_LO-1:0],
                         l2_desc[PAGE_OFF_W-1:0]};
endmodule

// File: rtl/xlat_desc_decode.sv
module xlat_desc_decode #(
  parameter int PAGE_OFF_W = 12,
  parameter int SUB_W      = 2,
  parameter int DOM_W      = 4
) (
  input  logic [PAGE_OFF_W-1:0] l1_lo,
  input  logic [PAGE_OFF_W-1:0] l2_lo,
  input  logic [SUB_W-1:0]      subpage,
  output logic                  l1_table,
  output logic                  l1_section,
  output logic                  l2_small,
  output logic [DOM_W-1:0]      domain,
  output logic [1:0]            sect_ap,
  output logic [1:0]            page_ap
);
  import xlat_pkg::*;

  localparam int NUM_SUB = 1 << SUB_W;
  localparam int AP_BASE = PAGE_OFF_W - 2 * NUM_SUB;
  localparam int DOM_LO  = 5;

  logic [1:0] sub_ap [NUM_SUB];

  generate
    for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
      assign sub_ap[g] = l2_lo[AP_BASE + 2*g +: 2];
    end
  endgenerate

  assign l1_table   = (l1_lo[1:0] == L1K_TABLE);
  assign l1_section = (l1_lo[1:0] == L1K_SECTION);
  assign l2_small   = (l2_lo[1:0] == L2K_SMALL);
  assign domain     = l1_lo[DOM_LO +: DOM_W];
  assign sect_ap    = l1_lo[PAGE_OFF_W-1 -: 2];
  assign page_ap    = sub_ap[subpage];

  logic unused_lo;
  assign unused_lo = ^{l1_lo[9], l1_lo[4:2], l2_lo[3:2]};
endmodule

// File: rtl/xlat_access_check.sv
module xlat_access_check #(
  parameter int DOM_W = 4
) (
  input  logic [2*(1<<DOM_W)-1:0] dac,
  input  logic [DOM_W-1:0]        domain,
  input  logic [1:0]              ap,
  input  logic                    is_user,
  input  logic                    is_write,
  output logic                    dom_fault,
  output logic                    perm_fault
);
  import xlat_pkg::*;

  localparam int NUM_DOM = 1 << DOM_W;

  logic [1:0] dmode [NUM_DOM];
  logic [1:0] mode;
  logic       manager;
  logic       ap_ok;

  generate
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      assign dmode[d] = dac[2*d +: 2];
    end
  endgenerate

  assign mode      = dmode[domain];
  assign dom_fault = ~mode[0];          // 00 and 10 both refuse
  assign manager   = (mode == 2'b11);

  always_comb begin
    case (ap)
      AP_NONE:    ap_ok = 1'b0;
      AP_SUPER:   ap_ok = ~is_user;
      AP_USER_RD: ap_ok = ~is_user | ~is_write;
      default:    ap_ok = 1'b1;
    endcase
  end

  assign perm_fault = ~manager & ~ap_ok;
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int ADDR_W     = 32,
  parameter int L1_IDX_W   = 12,
  parameter int L2_IDX_W   = 8,
  parameter int PAGE_OFF_W = 12,
  parameter int SUB_W      = 2,
  parameter int DOM_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [ADDR_W-1:0] cfg_ttb,
  input  logic [2*(1<<DOM_W)-1:0] cfg_dac,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              done,
  output logic              done_fault,
  output logic [2:0]        done_code,
  output logic [ADDR_W-1:0] done_pa,
  output logic              done_cacheable,
  output logic              done_bufferable,
  output logic [ADDR_W-1:0] done_fault_va
);
  import xlat_pkg::*;

  localparam int SUB_LO = PAGE_OFF_W - SUB_W;

  walk_st_e          state;
  logic [ADDR_W-1:0] va_q;
  logic              wr_q;
  logic              us_q;
  logic [ADDR_W-1:0] l1_q;
  logic [ADDR_W-1:0] l2_q;

  logic [ADDR_W-1:0] va_cur;
  logic [ADDR_W-1:0] l1_addr, l2_addr, sect_pa, page_pa;
  logic              l1_table, l1_section, l2_small;
  logic [DOM_W-1:0]  domain;
  logic [1:0]        sect_ap, page_ap, ap_sel;
  logic              dom_fault, perm_fault;

  logic              fin;
  logic              go_l2;
  fault_e            fin_code;
  logic [ADDR_W-1:0] fin_pa;
  logic              fin_c, fin_b;

  assign va_cur    = (state == ST_IDLE) ? req_vaddr : va_q;
  assign req_ready = (state == ST_IDLE);
  assign ap_sel    = (state == ST_L2_DECODE) ? page_ap : sect_ap;

  xlat_addr_gen #(
    .ADDR_W(ADDR_W), .L1_IDX_W(L1_IDX_W),
    .L2_IDX_W(L2_IDX_W), .PAGE_OFF_W(PAGE_OFF_W)
  ) u_addr (
    .ttb(cfg_ttb), .va(va_cur), .l1_desc(l1_q), .l2_desc(l2_q),
    .l1_addr(l1_addr), .l2_addr(l2_addr),
    .sect_pa(sect_pa), .page_pa(page_pa)
  );

  xlat_desc_decode #(
    .PAGE_OFF_W(PAGE_OFF_W), .SUB_W(SUB_W), .DOM_W(DOM_W)
  ) u_dec (
    .l1_lo(l1_q[PAGE_OFF_W-1:0]), .l2_lo(l2_q[PAGE_OFF_W-1:0]),
    .subpage(va_q[SUB_LO +: SUB_W]),
    .l1_table(l1_table), .l1_section(l1_section), .l2_small(l2_small),
    .domain(domain), .sect_ap(sect_ap), .page_ap(page_ap)
  );

  xlat_access_check #(.DOM_W(DOM_W)) u_chk (
    .dac(cfg_dac), .domain(domain), .ap(ap_sel),
    .is_user(us_q), .is_write(wr_q),
    .dom_fault(dom_fault), .perm_fault(perm_fault)
  );

  // outcome of the decode states, in priority order
  always_comb begin
    fin      = 1'b0;
    go_l2    = 1'b0;
    fin_code = FLT_NONE;
    fin_pa   = '0;
    fin_c    = 1'b0;
    fin_b    = 1'b0;
    case (state)
      ST_L1_DECODE: begin
        if (!l1_table && !l1_section) begin
          fin      = 1'b1;
          fin_code = FLT_L1_XLAT;
        end else if (dom_fault) begin
          fin      = 1'b1;
          fin_code = FLT_DOMAIN;
        end else if (l1_section) begin
          fin = 1'b1;
          if (perm_fault) begin
            fin_code = FLT_PERM;
          end else begin
            fin_pa = sect_pa;
            fin_c  = l1_q[3];
            fin_b  = l1_q[2];
          end
        end else begin
          go_l2 = 1'b1;
        end
      end
      ST_L2_DECODE: begin
        fin = 1'b1;
        if (!l2_small) begin
          fin_code = FLT_L2_XLAT;
        end else if (perm_fault) begin
          fin_code = FLT_PERM;
        end else begin
          fin_pa = page_pa;
          fin_c  = l2_q[3];
          fin_b  = l2_q[2];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      va_q            <= '0;
      wr_q            <= 1'b0;
      us_q            <= 1'b0;
      l1_q            <= '0;
      l2_q            <= '0;
      mem_req         <= 1'b0;
      mem_addr        <= '0;
      done            <= 1'b0;
      done_fault      <= 1'b0;
      done_code       <= 3'd0;
      done_pa         <= '0;
      done_cacheable  <= 1'b0;
      done_bufferable <= 1'b0;
      done_fault_va   <= '0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q     <= req_vaddr;
            wr_q     <= req_write;
            us_q     <= req_user;
            mem_req  <= 1'b1;
            mem_addr <= l1_addr;
            state    <= ST_L1_FETCH;
          end
        end
        ST_L1_FETCH: begin
          if (mem_rvalid) begin
            l1_q  <= mem_rdata;
            state <= ST_L1_DECODE;
          end
        end
        ST_L2_FETCH: begin
          if (mem_rvalid) begin
            l2_q  <= mem_rdata;
            state <= ST_L2_DECODE;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: begin
          if (go_l2) begin
            mem_req  <= 1'b1;
            mem_addr <= l2_addr;
            state    <= ST_L2_FETCH;
          end else if (fin) begin
            state           <= ST_DONE;
            done            <= 1'b1;
            done_fault      <= (fin_code != FLT_NONE);
            done_code       <= fin_code;
            done_pa         <= fin_pa;
            done_cacheable  <= fin_c;
            done_bufferable <= fin_b;
            done_fault_va   <= (fin_code != FLT_NONE) ? va_q : '0;
          end
        end
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_mem_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_resp_while_waiting_R10: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid |-> (state == ST_L1_FETCH || state == ST_L2_FETCH));

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_fault_clears_result_R9: assert property (@(posedge clk) disable iff (rst)
    (done && done_fault) |-> (done_pa == '0 && done_code != 3'd0 &&
                              !done_cacheable && !done_bufferable));

  assert_ok_has_no_code_R9: assert property (@(posedge clk) disable iff (rst)
    (done && !done_fault) |-> (done_code == 3'd0 && done_fault_va == '0));

  assert_no_strobe_when_done_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);

endmodule

// File: tb/xlat_walker_tb.sv
module xlat_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TTB = 32'h1234_E5A7;
  localparam logic [31:0] DAC = 32'hE4E4_E4E4; // domain n mode = n % 4

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, done_fault, done_cacheable, done_bufferable;
  logic [2:0]  done_code;
  logic [31:0] done_pa, done_fault_va;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] cur_d1, cur_d2, exp_l1, exp_l2;
  int          lat = 0;
  int          pend = 0;
  logic [31:0] pdata;
  int          rd_cnt = 0;
  logic [31:0] rd_addr0, rd_addr1;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_walker u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .cfg_ttb(TTB), .cfg_dac(DAC),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .done_fault(done_fault), .done_code(done_code),
    .done_pa(done_pa), .done_cacheable(done_cacheable),
    .done_bufferable(done_bufferable), .done_fault_va(done_fault_va)
  );

  task automatic summary_and_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary_and_end();
    end
  end

  // descriptor memory: answers each strobe once, after lat extra cycles
  always @(negedge clk) begin
    logic [31:0] data;
    mem_rvalid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = pdata;
      end
    end
    if (mem_req === 1'b1) begin
      if (rd_cnt == 0) rd_addr0 = mem_addr;
      else rd_addr1 = mem_addr;
      rd_cnt++;
      if (mem_addr == exp_l1) data = cur_d1;
      else if (mem_addr == exp_l2) data = cur_d2;
      else data = 32'h0;
      if (lat == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = data;
      end else begin
        pend  = lat;
        pdata = data;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic bit ap_allows(input logic [1:0] ap, input bit us, input bit wr);
    case (ap)
      2'd0: return 1'b0;
      2'd1: return !us;
      2'd2: return !us || !wr;
      default: return 1'b1;
    endcase
  endfunction

  task automatic run_case(input logic [31:0] va, input bit wr, input bit us,
                          input logic [31:0] d1, input logic [31:0] d2,
                          input int latency);
    int          e_code, e_reads, t;
    logic [31:0] e_pa;
    bit          e_c, e_b;
    logic [1:0]  dm, ap;
    string       tag;

    e_code = 0; e_reads = 1; e_pa = '0; e_c = 0; e_b = 0; tag = "R4";
    dm = DAC[2*d1[8:5] +: 2];
    if (d1[1:0] != 2'b01 && d1[1:0] != 2'b10) e_code = 1;
    else if (dm == 2'b00 || dm == 2'b10) e_code = 3;
    else if (d1[1:0] == 2'b10) begin
      ap = d1[11:10];
      if (dm != 2'b11 && !ap_allows(ap, us, wr)) e_code = 4;
      else begin e_pa = {d1[31:20], va[19:0]}; e_c = d1[3]; e_b = d1[2]; end
    end else begin
      e_reads = 2; tag = "R6";
      if (d2[1:0] != 2'b10) e_code = 2;
      else begin
        ap = d2[4 + 2*va[11:10] +: 2];
        if (dm != 2'b11 && !ap_allows(ap, us, wr)) e_code = 4;
        else begin e_pa = {d2[31:12], va[11:0]}; e_c = d2[3]; e_b = d2[2]; end
      end
    end
    case (e_code)
      1: tag = "R3";
      2: tag = "R6";
      3: tag = "R7";
      4: tag = "R8";
      default: ;
    endcase

    cur_d1 = d1; cur_d2 = d2; lat = latency;
    exp_l1 = {TTB[31:14], va[31:20], 2'b00};
    exp_l2 = {d1[31:10], va[19:12], 2'b00};

    @(negedge clk);
    rd_cnt = 0; rd_addr0 = '0; rd_addr1 = '0;
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = us;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 busy after accept", {31'd0, req_ready}, 32'd0);
    t = 0;
    while (done !== 1'b1 && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk(done === 1'b1, "R9 completion", {31'd0, done}, 32'd1);
    chk(done_code == e_code[2:0], tag, {29'd0, done_code}, e_code);
    chk(done_fault == (e_code != 0), "R9 fault flag", {31'd0, done_fault}, {31'd0, e_code != 0});
    chk(done_pa == e_pa, tag, done_pa, e_pa);
    chk({done_cacheable, done_bufferable} == {e_c, e_b}, tag,
        {30'd0, done_cacheable, done_bufferable}, {30'd0, e_c, e_b});
    chk(done_fault_va == ((e_code != 0) ? va : 32'd0), "R9 fault address",
        done_fault_va, (e_code != 0) ? va : 32'd0);
    chk(rd_cnt == e_reads, (e_code == 3) ? "R7 read count" : tag, rd_cnt, e_reads);
    chk(rd_addr0 == exp_l1, "R2 first-level address", rd_addr0, exp_l1);
    if (e_reads == 2)
      chk(rd_addr1 == exp_l2, "R5 second-level address", rd_addr1, exp_l2);
    @(negedge clk);
    chk(done == 1'b0, "R9 single-cycle done", {31'd0, done}, 32'd0);
  endtask

  initial begin
    int k;
    k = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(req_ready == 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);
    chk(done == 1'b0, "R1 done after reset", {31'd0, done}, 32'd0);
    chk(mem_req == 1'b0, "R1 no read after reset", {31'd0, mem_req}, 32'd0);

    // R3: every first-level kind, domain 1 (check mode), full permission
    for (int t = 0; t < 4; t++) begin
      run_case(32'hABC1_2F34 + t * 32'h0010_0400, 1'b1, 1'b1,
               32'h5550_0C3C | (32'd1 << 5) | t, 32'h7777_7FFE, t % 3);
    end

    // R4 R7 R8: sections over domains 0..7, all permission codes
    for (int dom = 0; dom < 8; dom++)
      for (int ap = 0; ap < 4; ap++)
        for (int us = 0; us < 2; us++)
          for (int wr = 0; wr < 2; wr++) begin
            k++;
            run_case(k * 32'h9E37_79B9, wr[0], us[0],
                     ((32'h0A5 + k) << 20) | (ap << 10) | (dom << 5) | 32'h10 |
                     ((ap & 1) << 3) | ((dom & 1) << 2) | 32'h2,
                     32'h0, k % 3);
          end

    // R5 R6 R7 R8: small pages, all subpages and domain modes
    for (int m = 0; m < 4; m++)
      for (int sub = 0; sub < 4; sub++)
        for (int a = 0; a < 4; a++)
          for (int us = 0; us < 2; us++)
            for (int wr = 0; wr < 2; wr++) begin
              logic [31:0] va, d2;
              k++;
              va = (k * 32'h6A09_E667) & ~32'h0000_0C00 | (sub << 10);
              d2 = ((32'h3C00_0 + k) << 12) | 32'h2 | ((a & 1) << 2) | ((us & 1) << 3);
              for (int f = 0; f < 4; f++) d2 |= ((a + f) % 4) << (4 + 2*f);
              run_case(va, wr[0], us[0],
                       32'h8000_0000 | (k << 10) | ((m + 4*sub) << 5) | 32'h11,
                       d2, k % 3);
            end

    // R6: every second-level kind under check and manager domains
    for (int t = 0; t < 4; t++)
      for (int m = 1; m < 4; m += 2) begin
        k++;
        run_case(32'h0123_4C56 + t * 32'h0000_1000, 1'b0, 1'b0,
                 32'h9000_0400 | (m << 5) | 32'h11,
                 32'hCAFE_B00C | (32'hFF0) | t, t % 3);
      end

    summary_and_end();
  end
endmodule